// File: doc/BRIEF.md
# Length-Prefixed Frame Receiver

The block sits behind a byte-level serial receiver. It takes one byte per valid strobe and splits the stream into frames. A frame starts with a fixed marker byte. Two length bytes follow, then the payload. The block hunts for the marker and discards any byte that is not the marker. It reads the declared payload length and passes exactly that many payload bytes on to a buffer write port. The first payload byte carries a start flag and the final one carries a last flag.

The block rejects a header whose length is zero or larger than the buffer capacity. It also aborts a frame when the receiver reports an overrun, or when a payload byte arrives while the downstream port is not ready. After any rejection or abort it returns to hunting and picks up the next marker cleanly. Completion and abort are each reported by a one-cycle pulse. Two saturating counters record aborted frames and discarded hunt bytes.

Payload bytes pass through combinationally in the cycle they are received. No byte is stored inside the block.

Top module: `frame_rx`

## Requirements
- R1: While hunting, a received byte other than 0x7E causes no output and no state change, and increments the junk counter by one.
- R2: The two bytes after a 0x7E marker form the payload length, with the low byte received first and the high byte second.
- R3: After a valid length of N, the next N received bytes are presented on the output in order, all of them including any 0x7E. The first byte carries out_sof_o and the Nth carries out_last_o. The block then hunts again.
- R4: frame_good_o pulses for exactly one cycle, in the cycle after the last payload byte is accepted.
- R5: A declared length of 0 delivers no byte. frame_drop_o pulses in the cycle after the high length byte, and the block hunts again.
- R6: A declared length above MAX_LEN (4096 by default) is dropped in the same way as R5. A length of exactly MAX_LEN is delivered in full.
- R7: rx_overrun_i high while the block is outside the hunting state aborts the frame. frame_drop_o pulses in the next cycle and no further byte is delivered until the next marker.
- R8: A payload byte that arrives while out_ready_i is low aborts the frame. The drop pulse and resynchronisation follow as in R7.
- R9: The drop counter increments once per abort or rejected length. Both counters hold at all ones (CNT_W bits wide) instead of wrapping.
- R10: After reset the block hunts, both pulses are low, and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A received byte is present |
| rx_data_i | input | 8 | Received byte |
| rx_overrun_i | input | 1 | Receiver overrun indication |
| out_ready_i | input | 1 | Downstream can take a byte |
| out_valid_o | output | 1 | Payload byte valid |
| out_data_o | output | 8 | Payload byte |
| out_sof_o | output | 1 | First byte of the frame |
| out_last_o | output | 1 | Final byte of the frame |
| frame_good_o | output | 1 | Frame completed pulse |
| frame_drop_o | output | 1 | Frame aborted or rejected pulse |
| drop_count_o | output | CNT_W | Saturating count of drops |
| junk_count_o | output | CNT_W | Saturating count of discarded hunt bytes |

## Verification
The hardest conditions to reach from the ports are counter saturation and the exact length boundary. The bench instantiates the block with narrow counters. It then drives long runs of junk bytes, and of marker-plus-overrun pairs, until both counters pin at all ones. It sends a length of MAX_LEN and one of MAX_LEN+1 back to back. After the rejected length, the trailing bytes must be counted as junk. A 300-byte frame exercises the byte order of the length field, since a high-byte-first reading would exceed the limit.

// File: rtl/frp_pkg.sv
package frp_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_LEN_LO = 2'd1,
    ST_LEN_HI = 2'd2,
    ST_PAY    = 2'd3
  } frp_state_e;

  localparam logic [7:0] MARK_BYTE = 8'h7E;
  localparam int unsigned LEN_W = 16;
endpackage

// File: rtl/frp_sat_cnt.sv
module frp_sat_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == CNT_MAX |=> cnt_o == CNT_MAX); // R9
endmodule

// File: rtl/frp_len_chk.sv
module frp_len_chk #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MAX_LEN = 4096
) (
  input  logic [LEN_W-1:0] len_i,
  output logic             ok_o
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  assign ok_o = (len_i != '0) && (len_i <= MAX_L);
endmodule

// File: rtl/frp_ctrl.sv
module frp_ctrl
  import frp_pkg::*;
#(
  parameter int unsigned MAX_LEN = 4096,
  localparam int unsigned REM_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_overrun_i,
  input  logic             out_ready_i,
  input  logic             len_ok_i,
  output logic [LEN_W-1:0] hdr_len_o,
  output logic             pay_fire_o,
  output logic             first_o,
  output logic             last_o,
  output logic             good_evt_o,
  output logic             drop_evt_o,
  output logic             junk_evt_o
);
  frp_state_e       state_q, state_d;
  logic [7:0]       len_lo_q, len_lo_d;
  logic [REM_W-1:0] remain_q, remain_d;
  logic             first_q, first_d;

  assign hdr_len_o  = {rx_data_i, len_lo_q};
  assign pay_fire_o = (state_q == ST_PAY) && rx_valid_i && !rx_overrun_i;
  assign first_o    = first_q;
  assign last_o     = (remain_q == REM_W'(1));

  always_comb begin
    state_d    = state_q;
    len_lo_d   = len_lo_q;
    remain_d   = remain_q;
    first_d    = first_q;
    good_evt_o = 1'b0;
    drop_evt_o = 1'b0;
    junk_evt_o = 1'b0;
    if (state_q == ST_HUNT) begin
      // overrun while hunting has nothing to abort
      if (rx_valid_i) begin
        if (rx_data_i == MARK_BYTE) state_d = ST_LEN_LO;
        else                        junk_evt_o = 1'b1;
      end
    end else if (rx_overrun_i) begin
      drop_evt_o = 1'b1;
      state_d    = ST_HUNT;
    end else if (rx_valid_i) begin
      unique case (state_q)
        ST_LEN_LO: begin
          len_lo_d = rx_data_i;
          state_d  = ST_LEN_HI;
        end
        ST_LEN_HI: begin
          if (len_ok_i) begin
            remain_d = hdr_len_o[REM_W-1:0];
            first_d  = 1'b1;
            state_d  = ST_PAY;
          end else begin
            drop_evt_o = 1'b1;
            state_d    = ST_HUNT;
          end
        end
        ST_PAY: begin
          if (!out_ready_i) begin
            drop_evt_o = 1'b1;
            state_d    = ST_HUNT;
          end else begin
            first_d = 1'b0;
            if (last_o) begin
              good_evt_o = 1'b1;
              state_d    = ST_HUNT;
            end else begin
              remain_d = remain_q - REM_W'(1);
            end
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      len_lo_q <= '0;
      remain_q <= '0;
      first_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      len_lo_q <= len_lo_d;
      remain_q <= remain_d;
      first_q  <= first_d;
    end
  end

  AST_OVR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_HUNT && rx_overrun_i) |=> state_q == ST_HUNT); // R7
  AST_STALL_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_fire_o && !out_ready_i) |=> state_q == ST_HUNT); // R8
  AST_BADLEN_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEN_HI && rx_valid_i && !rx_overrun_i && !len_ok_i)
      |=> state_q == ST_HUNT); // R5
  AST_LAST_TO_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_fire_o && out_ready_i && last_o) |=> state_q == ST_HUNT); // R3
  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(state_q == ST_PAY)) |-> remain_q != '0); // R6
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frp_pkg::*;
#(
  parameter int unsigned MAX_LEN = 4096,
  parameter int unsigned CNT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_overrun_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_sof_o,
  output logic             out_last_o,
  output logic             frame_good_o,
  output logic             frame_drop_o,
  output logic [CNT_W-1:0] drop_count_o,
  output logic [CNT_W-1:0] junk_count_o
);
  logic [LEN_W-1:0] hdr_len;
  logic len_ok, pay_fire, first, last;
  logic good_evt, drop_evt, junk_evt;
  logic good_q, drop_q;

  frp_len_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_len_chk (
    .len_i(hdr_len),
    .ok_o (len_ok)
  );

  frp_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .rx_overrun_i(rx_overrun_i),
    .out_ready_i (out_ready_i),
    .len_ok_i    (len_ok),
    .hdr_len_o   (hdr_len),
    .pay_fire_o  (pay_fire),
    .first_o     (first),
    .last_o      (last),
    .good_evt_o  (good_evt),
    .drop_evt_o  (drop_evt),
    .junk_evt_o  (junk_evt)
  );

  frp_sat_cnt #(.W(CNT_W)) u_drop_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (drop_evt),
    .cnt_o (drop_count_o)
  );

  frp_sat_cnt #(.W(CNT_W)) u_junk_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (junk_evt),
    .cnt_o (junk_count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      good_q <= good_evt;
      drop_q <= drop_evt;
    end
  end

  assign out_valid_o  = pay_fire;
  assign out_data_o   = rx_data_i;
  assign out_sof_o    = pay_fire && first;
  assign out_last_o   = pay_fire && last;
  assign frame_good_o = good_q;
  assign frame_drop_o = drop_q;

  AST_GOOD_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> frame_good_o); // R4
  AST_DROP_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_drop_o && $past(drop_count_o) != '1)
      |-> drop_count_o == $past(drop_count_o) + CNT_W'(1)); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_good_o && frame_drop_o)); // R4
endmodule

// File: tb/tb_frame_rx.sv
module tb_frame_rx;
  localparam int CLK_P   = 10;
  localparam int MAX_LEN = 4096;
  localparam int CNT_W   = 8;
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic clk = 0, rst_ni = 0;
  logic rx_valid = 0, rx_overrun = 0, out_ready = 1;
  logic [7:0] rx_data = 0;
  logic out_valid, out_sof, out_last, frame_good, frame_drop;
  logic [7:0] out_data;
  logic [CNT_W-1:0] drop_count, junk_count;

  always #(CLK_P/2) clk = ~clk;

  frame_rx #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_overrun_i(rx_overrun), .out_ready_i(out_ready), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_sof_o(out_sof), .out_last_o(out_last),
    .frame_good_o(frame_good), .frame_drop_o(frame_drop),
    .drop_count_o(drop_count), .junk_count_o(junk_count));

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int m_st = 0, m_lo = 0, m_rem = 0;
  bit m_first = 0, m_good = 0, m_drop = 0;
  int m_junk = 0, m_dropc = 0, m_frames = 0;
  byte sent_q[$];
  byte got_q[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit v, byte d, bit ovr, bit rdy);
    bit ev;
    @(negedge clk);
    rx_valid = v; rx_data = d; rx_overrun = ovr; out_ready = rdy;
    #1;
    ev = (m_st == 3) && v && !ovr;
    chk(out_valid == ev, "R3 valid", out_valid, ev);
    if (ev) begin
      chk(out_data == d, "R3 data", out_data, d);
      chk(out_sof == m_first, "R3 sof", out_sof, m_first);
      chk(out_last == (m_rem == 1), "R3 last", out_last, m_rem == 1);
      if (rdy) got_q.push_back(out_data);
    end
    chk(frame_good == m_good, "R4 good pulse", frame_good, m_good);
    chk(frame_drop == m_drop, "R5,R7,R8 drop pulse", frame_drop, m_drop);
    chk(junk_count == m_junk, "R1 junk count", junk_count, m_junk);
    chk(drop_count == m_dropc, "R9 drop count", drop_count, m_dropc);
    @(posedge clk);
    m_good = 0; m_drop = 0;
    if (m_st == 0) begin
      if (v) begin
        if (d == 8'h7E) m_st = 1;
        else if (m_junk < CMAX) m_junk++;
      end
    end else if (ovr) begin
      m_drop = 1; m_st = 0;
    end else if (v) begin
      case (m_st)
        1: begin m_lo = int'(d) & 255; m_st = 2; end
        2: begin
          int len;
          len = (int'(d) & 255) * 256 + m_lo;
          if (len == 0 || len > MAX_LEN) begin m_drop = 1; m_st = 0; end
          else begin m_rem = len; m_first = 1; m_st = 3; sent_q.delete(); got_q.delete(); end
        end
        default: begin
          if (!rdy) begin m_drop = 1; m_st = 0; end
          else begin
            sent_q.push_back(d);
            m_first = 0;
            if (m_rem == 1) begin
              m_good = 1; m_st = 0; m_frames++;
              chk(got_q.size() == sent_q.size(), "R3 frame size", got_q.size(), sent_q.size());
              foreach (sent_q[i])
                if (i < got_q.size()) chk(got_q[i] == sent_q[i], "R3 frame byte", got_q[i], sent_q[i]);
            end else m_rem--;
          end
        end
      endcase
    end
    if (m_drop && m_dropc < CMAX) m_dropc++;
  endtask

  task automatic tx(byte d); step(1, d, 0, 1); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(0, 8'h00, 0, 1); endtask

  task automatic header(int len);
    tx(8'h7E); tx(byte'(len & 255)); tx(byte'((len >> 8) & 255));
  endtask

  task automatic frame(int len, int seed);
    header(len);
    for (int i = 0; i < len; i++) tx(byte'((i * 37 + seed) & 255));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(out_valid == 0 && frame_good == 0 && frame_drop == 0, "R10 outputs", out_valid, 0);
    chk(drop_count == 0 && junk_count == 0, "R10 counters", drop_count + junk_count, 0);
    rst_ni = 1;
    idle(2);

    // R1 junk then good frame, R2 R3 R4
    tx(8'h00); tx(8'h41); tx(8'hFF);
    frame(5, 3);
    idle(2);
    chk(m_frames == 1, "R4 first frame done", m_frames, 1);

    // R3 marker inside payload, gaps between bytes
    header(3);
    tx(8'h7E); idle(2); tx(8'h7E); idle(1); tx(8'h10);
    idle(2);

    // R5 zero length
    header(0);
    tx(8'h55);
    idle(2);

    // R6 over limit, trailing bytes become junk
    header(MAX_LEN + 1);
    tx(8'h01); tx(8'h02);
    idle(1);
    frame(MAX_LEN, 11);
    idle(2);

    // R2 low byte first: 300 = 0x012C
    frame(300, 5);
    idle(2);
    chk(m_frames == 4, "R2 R6 frames delivered", m_frames, 4);

    // R7 overrun in each non-hunt state
    tx(8'h7E); step(0, 8'h00, 1, 1); idle(1);
    tx(8'h7E); tx(8'h04); step(1, 8'h00, 1, 1); idle(1);
    header(4); tx(8'hA1); step(1, 8'hA2, 1, 1); tx(8'hA3); idle(2);
    // overrun while hunting has no effect
    step(0, 8'h00, 1, 1); frame(2, 9); idle(2);

    // R8 downstream not ready
    header(4); tx(8'h01); step(1, 8'h02, 0, 0); tx(8'h03); idle(2);
    frame(1, 1); idle(2);
    chk(m_frames == 6, "R7 R8 recovery frames", m_frames, 6);

    // R9 saturation of both counters
    for (int i = 0; i < CMAX + 5; i++) tx(8'h33);
    for (int i = 0; i < CMAX + 5; i++) begin tx(8'h7E); step(0, 8'h00, 1, 1); end
    idle(2);
    @(negedge clk); #1;
    chk(junk_count == CMAX, "R9 junk saturates", junk_count, CMAX);
    chk(drop_count == CMAX, "R9 drop saturates", drop_count, CMAX);
    frame(2, 4); idle(2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule